// File: doc/BRIEF.md
# Dual-Link Pixel Router

This block connects two incoming pixel links to two outgoing pixel links. Each link carries one 35-bit pixel word per clock, together with a valid strobe. The valid strobe also serves as the data-enable of the video stream. A routing mode is latched at reset and selects one of four behaviours:

- **Straight pass:** each input link drives its own output link.
- **Broadcast:** input link 1 is copied onto both output links.
- **Split:** a fast stream on link 1 is divided into two half-rate streams, one pixel per output link.
- **Merge:** two half-rate streams are interleaved into one fast stream on output link 1.

Each mode has its own fixed pipeline latency. The whole model runs on one fast clock. A half-rate link pixel lasts two fast cycles, and that two-cycle phase is aligned to the rising edge of link 1's data-enable. The phase keeps the first and second pixel of every pair together, and an error pulse marks any enable run of odd length in the modes that pair pixels. A power-down input idles every output and discards the words in flight.

The links are synchronous video streams with no back-pressure. A word is consumed in every cycle in which its valid bit is high, and an output word is meaningful only in cycles where its valid bit is high. There is no ready signal in either direction. The output-enable pins stand in for tri-state output drivers: a disabled link drives zero data and a low valid bit.

Top module: `pxr_router`

## Requirements
- R1: The routing mode is sampled from `mode_sel` only while `rst_n` is low. The encodings are 00 straight pass, 01 broadcast, 10 split and 11 merge. Changing `mode_sel` after reset has no effect on routing.
- R2: In straight pass, a word presented on input link 1 (or 2) in cycle c appears on output link 1 (or 2) in cycle c+4, with the same valid bit.
- R3: In broadcast, a word presented on input link 1 in cycle c appears on both output links in cycle c+4. Input link 2 does not affect any output.
- R4: In split, pixels of a link 1 enable run are paired from the first valid cycle onward. The first pixel of a pair (cycle s) is placed on output link 1 and the second (cycle s+1) on output link 2. Both appear in cycles s+6 and s+7 with valid high. Input link 2 does not affect any output.
- R5: In split, when an enable run has odd length, its last pixel appears alone on output link 1, and output link 2 keeps valid low in those two cycles.
- R6: In merge, both inputs are sampled in the first fast cycle s of each two-cycle link pixel. Phases are counted from the rise of input link 1's valid. Output link 1 carries the link 1 word in cycle s+3 and the link 2 word in cycle s+4, each for one cycle. The valid bit in s+4 is the valid bit that link 2 had in cycle s.
- R7: In merge, output link 2 has its output enable low, its valid low and its data zero.
- R8: In split and merge, when the valid bit of input link 1 falls after a run of odd length, `pair_err` is high for exactly the one cycle that follows the first low cycle. Even runs, and every run in straight pass or broadcast, leave `pair_err` low.
- R9: While `pwr_dn` is high, all output enables, valid bits, data and `pair_err` are zero in that same cycle. Words accepted before or during power-down never appear afterwards.
- R10: After reset, both valid outputs and `pair_err` are low. Output link 1 is enabled, and output link 2 is enabled in every mode except merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; mode is sampled while low |
| mode_sel | input | 2 | Routing mode code |
| pwr_dn | input | 1 | Power-down: idles outputs and flushes the pipelines |
| in1_data | input | 35 | Input link 1 pixel word |
| in1_valid | input | 1 | Input link 1 valid / data-enable |
| in2_data | input | 35 | Input link 2 pixel word |
| in2_valid | input | 1 | Input link 2 valid / data-enable |
| out1_data | output | 35 | Output link 1 pixel word |
| out1_valid | output | 1 | Output link 1 valid |
| out1_oe | output | 1 | Output link 1 driver enable |
| out2_data | output | 35 | Output link 2 pixel word |
| out2_valid | output | 1 | Output link 2 valid |
| out2_oe | output | 1 | Output link 2 driver enable |
| pair_err | output | 1 | One-cycle pulse on an odd-length enable run |

## Verification
The hardest case to reach is the end of an odd-length enable run in split mode. It needs the phase to sit on a second-of-pair slot while the valid bit is low, and it produces three effects in different cycles: a lone pixel on link 1, a silent link 2, and a delayed error pulse. The stimulus drives runs that start on odd cycle numbers and have odd lengths, and then checks that a fresh run realigns the pairing. Power-down is asserted while words sit in the pipeline, so the flush can be observed as the absence of those words once the outputs come back.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
  localparam int PIX_W     = 35;
  localparam int LAT_DUAL  = 4;
  localparam int LAT_SPLIT = 6;
  localparam int LAT_MERGE = 3;
  // head stage is shared by every mode, tail is skipped in merge
  localparam int HEAD_D    = LAT_MERGE - 1;
  localparam int TAIL_D    = LAT_DUAL - HEAD_D;
  // cycles spent forming a pair before the shared pipe
  localparam int PAIR_D    = LAT_SPLIT - LAT_DUAL;

  typedef enum logic [1:0] {
    RT_DUAL  = 2'b00,
    RT_BCAST = 2'b01,
    RT_SPLIT = 2'b10,
    RT_MERGE = 2'b11
  } route_e;
endpackage

// File: rtl/pxr_delay_pipe.sv
module pxr_delay_pipe #(
  parameter int W     = 35,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic         v_s [DEPTH+1];
  logic [W-1:0] d_s [DEPTH+1];

  assign v_s[0] = in_v;
  assign d_s[0] = in_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_s[i+1] <= 1'b0;
          d_s[i+1] <= '0;
        end else if (clr) begin
          v_s[i+1] <= 1'b0;
          d_s[i+1] <= '0;
        end else begin
          v_s[i+1] <= v_s[i];
          d_s[i+1] <= d_s[i];
        end
      end
    end
  endgenerate

  assign out_v = v_s[DEPTH];
  assign out_d = d_s[DEPTH];

  AST_PIPE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_v); // R9
endmodule

// File: rtl/pxr_pair_phase.sv
module pxr_pair_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vin,
  input  logic chk_en,
  output logic ph,
  output logic odd_err
);
  logic ph_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (clr) begin
      ph_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ph_q  <= vin ? ~ph_q : 1'b0;
      err_q <= chk_en & ph_q & ~vin;
    end
  end

  assign ph      = ph_q;
  assign odd_err = err_q;

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R8
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!vin) |=> !ph_q); // R4
endmodule

// File: rtl/pxr_split_unit.sv
module pxr_split_unit #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ph,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         p0_v,
  output logic [W-1:0] p0_d,
  output logic         p1_v,
  output logic [W-1:0] p1_d
);
  logic [W-1:0] hold_q, p0_q, p1_q;
  logic         pv_q, p1v_q, age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      p0_q   <= '0;
      p1_q   <= '0;
      pv_q   <= 1'b0;
      p1v_q  <= 1'b0;
      age_q  <= 1'b0;
    end else if (clr) begin
      hold_q <= '0;
      p0_q   <= '0;
      p1_q   <= '0;
      pv_q   <= 1'b0;
      p1v_q  <= 1'b0;
      age_q  <= 1'b0;
    end else begin
      if (!ph && vin) hold_q <= din;
      if (ph) begin
        p0_q  <= hold_q;
        p1_q  <= din;
        pv_q  <= 1'b1;
        p1v_q <= vin;
        age_q <= 1'b0;
      end else if (pv_q) begin
        if (!age_q) begin
          age_q <= 1'b1;
        end else begin
          pv_q  <= 1'b0;
          p1v_q <= 1'b0;
        end
      end
    end
  end

  assign p0_v = pv_q;
  assign p0_d = p0_q;
  assign p1_v = p1v_q;
  assign p1_d = p1_q;

  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !age_q && !clr) |=> (pv_q && $stable(p0_q) && $stable(p1_q))); // R4
  AST_SPLIT_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    p1v_q |-> pv_q); // R5
endmodule

// File: rtl/pxr_merge_unit.sv
module pxr_merge_unit #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ph,
  input  logic         v1,
  input  logic [W-1:0] d1,
  input  logic         v2,
  input  logic [W-1:0] d2,
  output logic         m_v,
  output logic [W-1:0] m_d
);
  logic [W-1:0] a_q, b_q;
  logic         bv_q;
  logic [1:0]   slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      bv_q   <= 1'b0;
      slot_q <= 2'd0;
    end else if (clr) begin
      a_q    <= '0;
      b_q    <= '0;
      bv_q   <= 1'b0;
      slot_q <= 2'd0;
    end else if (!ph && v1) begin
      a_q    <= d1;
      b_q    <= d2;
      bv_q   <= v2;
      slot_q <= 2'd1;
    end else if (slot_q == 2'd1) begin
      slot_q <= 2'd2;
    end else begin
      slot_q <= 2'd0;
    end
  end

  always_comb begin
    m_v = 1'b0;
    m_d = a_q;
    if (slot_q == 2'd1) begin
      m_v = 1'b1;
    end else if (slot_q == 2'd2) begin
      m_v = bv_q;
      m_d = b_q;
    end
  end

  AST_MERGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == 2'd1 && !clr) |=> (slot_q == 2'd2)); // R6
endmodule

// File: rtl/pxr_router.sv
module pxr_router #(
  parameter int PIX_W = pxr_pkg::PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             pwr_dn,
  input  logic [PIX_W-1:0] in1_data,
  input  logic             in1_valid,
  input  logic [PIX_W-1:0] in2_data,
  input  logic             in2_valid,
  output logic [PIX_W-1:0] out1_data,
  output logic             out1_valid,
  output logic             out1_oe,
  output logic [PIX_W-1:0] out2_data,
  output logic             out2_valid,
  output logic             out2_oe,
  output logic             pair_err
);
  import pxr_pkg::*;

  route_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= route_e'(mode_sel);
  end

  logic is_split, is_merge, pairing, active;
  assign is_split = (mode_q == RT_SPLIT);
  assign is_merge = (mode_q == RT_MERGE);
  assign pairing  = is_split | is_merge;
  assign active   = ~pwr_dn;

  // phase and odd-run detection on link 1
  logic ph, odd_err;
  pxr_pair_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pwr_dn),
    .vin    (in1_valid),
    .chk_en (pairing),
    .ph     (ph),
    .odd_err(odd_err)
  );

  logic             p0_v, p1_v;
  logic [PIX_W-1:0] p0_d, p1_d;
  pxr_split_unit #(.W(PIX_W)) u_split (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pwr_dn | ~is_split),
    .ph   (ph),
    .vin  (in1_valid),
    .din  (in1_data),
    .p0_v (p0_v),
    .p0_d (p0_d),
    .p1_v (p1_v),
    .p1_d (p1_d)
  );

  logic             m_v;
  logic [PIX_W-1:0] m_d;
  pxr_merge_unit #(.W(PIX_W)) u_merge (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pwr_dn | ~is_merge),
    .ph   (ph),
    .v1   (in1_valid),
    .d1   (in1_data),
    .v2   (in2_valid),
    .d2   (in2_data),
    .m_v  (m_v),
    .m_d  (m_d)
  );

  // source selection for the two lanes
  logic             h_in_v, l2_in_v;
  logic [PIX_W-1:0] h_in_d, l2_in_d;
  always_comb begin
    h_in_v  = in1_valid;
    h_in_d  = in1_data;
    l2_in_v = in2_valid;
    l2_in_d = in2_data;
    unique case (mode_q)
      RT_DUAL: ;
      RT_BCAST: begin
        l2_in_v = in1_valid;
        l2_in_d = in1_data;
      end
      RT_SPLIT: begin
        h_in_v  = p0_v;
        h_in_d  = p0_d;
        l2_in_v = p1_v;
        l2_in_d = p1_d;
      end
      RT_MERGE: begin
        h_in_v  = m_v;
        h_in_d  = m_d;
        l2_in_v = 1'b0;
        l2_in_d = '0;
      end
      default: ;
    endcase
  end

  logic             h_v, t_v, l2_v;
  logic [PIX_W-1:0] h_d, t_d, l2_d;

  pxr_delay_pipe #(.W(PIX_W), .DEPTH(HEAD_D)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
    .in_v(h_in_v), .in_d(h_in_d), .out_v(h_v), .out_d(h_d)
  );
  pxr_delay_pipe #(.W(PIX_W), .DEPTH(TAIL_D)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
    .in_v(h_v), .in_d(h_d), .out_v(t_v), .out_d(t_d)
  );
  pxr_delay_pipe #(.W(PIX_W), .DEPTH(LAT_DUAL)) u_lane2 (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
    .in_v(l2_in_v), .in_d(l2_in_d), .out_v(l2_v), .out_d(l2_d)
  );

  // output drivers
  logic             o1_v;
  logic [PIX_W-1:0] o1_d;
  assign o1_v = is_merge ? h_v : t_v;
  assign o1_d = is_merge ? h_d : t_d;

  assign out1_oe    = active;
  assign out1_valid = active & o1_v;
  assign out1_data  = active ? o1_d : '0;
  assign out2_oe    = active & ~is_merge;
  assign out2_valid = out2_oe & l2_v;
  assign out2_data  = out2_oe ? l2_d : '0;
  assign pair_err   = active & odd_err;

  AST_ERR_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> pairing); // R8
  AST_MERGE_LANE2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_merge |-> !l2_v); // R7
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !(h_v || l2_v)); // R9
endmodule

// File: tb/pxr_router_tb_top.sv
module pxr_router_tb_top;
  localparam int W = 35;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         pwr_dn = 1'b0;
  logic [W-1:0] in1_data = '0, in2_data = '0;
  logic         in1_valid = 1'b0, in2_valid = 1'b0;
  logic [W-1:0] out1_data, out2_data;
  logic         out1_valid, out1_oe, out2_valid, out2_oe, pair_err;

  always #5 clk = ~clk;

  pxr_router dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pwr_dn(pwr_dn),
    .in1_data(in1_data), .in1_valid(in1_valid),
    .in2_data(in2_data), .in2_valid(in2_valid),
    .out1_data(out1_data), .out1_valid(out1_valid), .out1_oe(out1_oe),
    .out2_data(out2_data), .out2_valid(out2_valid), .out2_oe(out2_oe),
    .pair_err(pair_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] h1 [64];
  logic [W-1:0] h2 [64];
  logic         hv1 [64];
  logic         hv2 [64];
  logic         hp [65];
  int           pd_lo, pd_hi;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int j = 0; j < 64; j++) begin
      h1[j] = '0; h2[j] = '0; hv1[j] = 1'b0; hv2[j] = 1'b0;
    end
    pd_lo = 1000;
    pd_hi = -1;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    pwr_dn = 1'b0;
    in1_valid = 1'b0; in2_valid = 1'b0;
    in1_data = '0; in2_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out1_valid == 1'b0, "R10", "out1_valid", 64'(out1_valid), 0);
    chk(out2_valid == 1'b0, "R10", "out2_valid", 64'(out2_valid), 0);
    chk(pair_err == 1'b0, "R10", "pair_err", 64'(pair_err), 0);
    chk(out1_oe == 1'b1, "R10", "out1_oe", 64'(out1_oe), 1);
    chk(out2_oe == (m != 2'b11), "R10", "out2_oe", 64'(out2_oe), 64'(m != 2'b11));
  endtask

  // drives the prepared history and checks every output in every cycle
  task automatic run_cycles(input int n, input logic [1:0] m, input string rq_main);
    hp[0] = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic         pd, e1v, e2v, oe1, oe2, eerr;
      logic [W-1:0] e1d, e2d;
      int           s;
      string        rq, rq2;
      @(negedge clk);
      pd = (k >= pd_lo) && (k <= pd_hi);
      pwr_dn    = pd;
      in1_data  = h1[k];  in1_valid = hv1[k];
      in2_data  = h2[k];  in2_valid = hv2[k];
      #1;
      if (pd) for (int j = 0; j <= k; j++) begin hv1[j] = 1'b0; hv2[j] = 1'b0; end
      e1v = 1'b0; e2v = 1'b0; e1d = '0; e2d = '0;
      oe1 = 1'b1; oe2 = (m != 2'b11);
      case (m)
        2'b00, 2'b01: if (k >= 4) begin
          e1v = hv1[k-4]; e1d = h1[k-4];
          e2v = (m == 2'b00) ? hv2[k-4] : hv1[k-4];
          e2d = (m == 2'b00) ? h2[k-4] : h1[k-4];
        end
        2'b10: begin
          s = -1;
          if (k >= 6 && hv1[k-6] && !hp[k-6]) s = k - 6;
          else if (k >= 7 && hv1[k-7] && !hp[k-7]) s = k - 7;
          if (s >= 0) begin
            e1v = 1'b1; e1d = h1[s]; e2v = hv1[s+1]; e2d = h1[s+1];
          end
        end
        default: begin
          if (k >= 3 && hv1[k-3] && !hp[k-3]) begin
            e1v = 1'b1; e1d = h1[k-3];
          end else if (k >= 4 && hv1[k-4] && !hp[k-4]) begin
            e1v = hv2[k-4]; e1d = h2[k-4];
          end
        end
      endcase
      eerr = m[1] && (k >= 1) && hp[k-1] && !hv1[k-1];
      if (pd) begin
        e1v = 1'b0; e2v = 1'b0; oe1 = 1'b0; oe2 = 1'b0; eerr = 1'b0;
      end
      rq  = pd ? "R9" : rq_main;
      rq2 = pd ? "R9" : ((m == 2'b11) ? "R7" : rq_main);
      chk(out1_oe == oe1, rq, "out1_oe", 64'(out1_oe), 64'(oe1));
      chk(out1_valid == e1v, rq, "out1_valid", 64'(out1_valid), 64'(e1v));
      if (e1v) chk(out1_data == e1d, rq, "out1_data", 64'(out1_data), 64'(e1d));
      if (!oe1) chk(out1_data == '0, rq, "out1_data_off", 64'(out1_data), 0);
      chk(out2_oe == oe2, rq2, "out2_oe", 64'(out2_oe), 64'(oe2));
      chk(out2_valid == e2v, rq2, "out2_valid", 64'(out2_valid), 64'(e2v));
      if (e2v) chk(out2_data == e2d, rq2, "out2_data", 64'(out2_data), 64'(e2d));
      if (!oe2) chk(out2_data == '0, rq2, "out2_data_off", 64'(out2_data), 0);
      chk(pair_err == eerr, pd ? "R9" : "R8", "pair_err", 64'(pair_err), 64'(eerr));
      hp[k+1] = pd ? 1'b0 : (hv1[k] ? !hp[k] : 1'b0);
    end
    @(negedge clk);
    in1_valid = 1'b0; in2_valid = 1'b0; pwr_dn = 1'b0;
  endtask

  // R1 and R2: straight pass while mode_sel moves after reset; odd run gives no error (R8)
  task automatic test_straight_latched();
    clear_hist();
    do_reset(2'b00);
    mode_sel = 2'b11;
    for (int k = 0; k < 12; k++) begin
      h1[k] = 35'h4_A000_0000 + 35'(k);
      h2[k] = 35'h2_B000_0000 + 35'(k * 3);
      hv1[k] = (k <= 4) || (k >= 7 && k <= 9);
      hv2[k] = (k >= 1 && k <= 3) || (k >= 8);
    end
    run_cycles(20, 2'b00, "R1");
  endtask

  // R3: broadcast, link 2 carries junk that must not show
  task automatic test_broadcast();
    clear_hist();
    do_reset(2'b01);
    for (int k = 0; k < 14; k++) begin
      h1[k] = 35'h1_C000_0000 + 35'(k);
      h2[k] = 35'h7_FFFF_0000 - 35'(k);
      hv1[k] = (k <= 5);
      hv2[k] = 1'b1;
    end
    run_cycles(16, 2'b01, "R3");
  endtask

  // R4: split of even runs, link 2 junk ignored
  task automatic test_split_even();
    clear_hist();
    do_reset(2'b10);
    for (int k = 0; k < 16; k++) begin
      h1[k] = 35'h3_D000_0000 + 35'(k * 5);
      h2[k] = 35'h5_5555_5555;
      hv1[k] = (k <= 7) || (k >= 10 && k <= 13);
      hv2[k] = 1'b1;
    end
    run_cycles(24, 2'b10, "R4");
  endtask

  // R5 and R8: odd run starting on an odd cycle, then realignment
  task automatic test_split_odd();
    clear_hist();
    do_reset(2'b10);
    for (int k = 0; k < 18; k++) begin
      h1[k] = 35'h6_E000_0000 + 35'(k);
      hv1[k] = (k >= 3 && k <= 7) || (k >= 11 && k <= 14);
    end
    run_cycles(26, 2'b10, "R5");
  endtask

  // R6, R7 and R8: merge of two-cycle pixels, then an odd run
  task automatic test_merge();
    clear_hist();
    do_reset(2'b11);
    for (int k = 0; k < 16; k++) begin
      h1[k] = 35'h0_F000_0000 + 35'(k / 2);
      h2[k] = 35'h1_1000_0000 + 35'((k / 2) * 7);
      hv1[k] = (k <= 5) || (k >= 9 && k <= 13);
      hv2[k] = (k <= 3) || (k >= 9);
    end
    run_cycles(22, 2'b11, "R6");
  endtask

  // R9: power-down with words in flight
  task automatic test_power_down();
    clear_hist();
    do_reset(2'b00);
    for (int k = 0; k < 8; k++) begin
      h1[k] = 35'h2_2200_0000 + 35'(k);
      h2[k] = 35'h3_3300_0000 + 35'(k);
      hv1[k] = (k <= 5);
      hv2[k] = (k <= 5);
    end
    pd_lo = 3;
    pd_hi = 4;
    run_cycles(14, 2'b00, "R9");
  endtask

  initial begin
    test_straight_latched();
    test_broadcast();
    test_split_even();
    test_split_odd();
    test_merge();
    test_power_down();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule